// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources and presents one vectored request to a CPU core. The sources are two active-low external pins, two timer overflow events, a serial port request and a timer 2 request. Software supplies a global enable, a per-source enable mask, a per-source priority bit and, for each external pin, a trigger type. The controller selects the winning source, drives a request with its vector address, and tracks which priority levels are in service. The CPU acknowledges the request when it enters a handler and pulses a return signal when the handler ends.

Sources are numbered 0 to 5 in polling order: external 0, timer 0, external 1, timer 1, serial, timer 2. The same numbering gives the bit position in both the enable mask and the priority mask, and the vector address is derived from it. Two in-service levels are kept. A high-priority request may preempt a running low-priority handler, but nothing preempts a high-priority handler. The external pins are either level sensitive or falling-edge latched. The timer 0 and timer 1 overflow pulses are latched, and those flags clear on acknowledge. The serial and timer 2 inputs are levels that the source logic owns.

The service tracker is a state machine with four states. SVC_IDLE means no handler runs. SVC_LOW means a low-priority handler runs. SVC_HIGH means a high-priority handler runs with nothing beneath it. SVC_NEST means a high-priority handler has preempted a low one. An accepted acknowledge moves SVC_IDLE to SVC_LOW or SVC_HIGH according to the winner's level, and moves SVC_LOW to SVC_NEST. A return moves SVC_NEST to SVC_LOW, and moves SVC_LOW or SVC_HIGH to SVC_IDLE. In SVC_IDLE a return is ignored.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When `gie` is 0, `irq_req` stays low whatever is pending.
- R2: `src_en` bit i enables source i, with bits 0..5 mapped to external 0, timer 0, external 1, timer 1, serial, timer 2. A disabled source is never presented.
- R3: `src_prio` uses the same bit layout, and a 1 marks a source high priority. When a high-level request is eligible, it wins over any low-level request.
- R4: Among eligible sources of the same level, the lowest index wins.
- R5: `irq_vec` equals 0x0003 + 8 × index: 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B for indices 0 to 5.
- R6: While a low-level handler runs, only high-level requests are presented.
- R7: While a high-level handler runs (SVC_HIGH or SVC_NEST), no request is presented.
- R8: `irq_ret` ends the most recently entered level. From SVC_NEST it returns to SVC_LOW, and from SVC_LOW or SVC_HIGH it returns to SVC_IDLE.
- R9: With `ext_type` bit p at 1, a falling edge on `ext_n[p]` latches a request. The request stays after the pin rises and is cleared by the acknowledge that takes it. A pin held low after that acknowledge does not request again.
- R10: With `ext_type` bit p at 0, external source p requests exactly while `ext_n[p]` is low. Nothing is latched.
- R11: A one-cycle `tmr0_ovf` or `tmr1_ovf` pulse latches a request that holds until the acknowledge that takes it.
- R12: `ser_req` and `tmr2_req` are not cleared by an acknowledge. They are presented again as long as they stay high and their level allows it.
- R13: An `irq_ack` while `irq_req` is low, or in the same cycle as `irq_ret`, changes neither the service state nor any latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, bit i = source i |
| src_prio | input | 6 | Per-source priority, 1 = high |
| ext_type | input | 2 | Per-pin trigger: 1 = falling edge, 0 = low level |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_req | input | 1 | Serial receive/transmit request level |
| tmr2_req | input | 1 | Timer 2 request level |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | CPU leaves the current handler |
| irq_req | output | 1 | A vectored request is presented |
| irq_vec | output | 16 | Vector address of the presented request |

## Verification
A wrong service state shows at the ports in the first cycle after the faulty transition. Either a pending low request is presented while it should be masked, or a pending high request vanishes or persists when it should not. A flag that fails to latch or clear shows as a missing or lingering `irq_req` one clock after the edge, pulse or acknowledge. Arbitration faults show at once as a wrong `irq_vec` under the given pending pattern.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC  = 6;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int NUM_PINS = 2;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_LOW  = 2'd1,
        SVC_HIGH = 2'd2,
        SVC_NEST = 2'd3
    } svc_state_t;
endpackage

// File: rtl/irqc_pin_detect.sv
module irqc_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (!edge_mode)
                flag_q <= 1'b0;
            else if (prev_q && !pin_n)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? flag_q : ~pin_n;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NSRC = 6,
    parameter int IW   = 3
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en_mask,
    input  logic            glob,
    input  logic [NSRC-1:0] prio,
    input  logic            allow_hi,
    input  logic            allow_lo,
    output logic            valid,
    output logic [IW-1:0]   idx,
    output logic            is_hi
);
    logic [NSRC-1:0] elig, hi_set, lo_set;
    logic            hi_f, lo_f;
    logic [IW-1:0]   hi_i, lo_i;

    always_comb begin
        elig   = pend & en_mask & {NSRC{glob}};
        hi_set = elig & prio;
        lo_set = elig & ~prio;
        hi_f = 1'b0;
        lo_f = 1'b0;
        hi_i = '0;
        lo_i = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_set[i]) begin
                hi_f = 1'b1;
                hi_i = IW'(i);
            end
            if (lo_set[i]) begin
                lo_f = 1'b1;
                lo_i = IW'(i);
            end
        end
        if (hi_f) begin
            valid = allow_hi;
            idx   = hi_i;
            is_hi = 1'b1;
        end else begin
            valid = lo_f && allow_lo;
            idx   = lo_i;
            is_hi = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_svc_fsm.sv
module irqc_svc_fsm
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_hi,
    input  logic       ret,
    output svc_state_t state,
    output logic       allow_hi,
    output logic       allow_lo
);
    svc_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SVC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SVC_IDLE: if (take) nxt = take_hi ? SVC_HIGH : SVC_LOW;
            SVC_LOW: begin
                if (ret)       nxt = SVC_IDLE;
                else if (take) nxt = SVC_NEST;
            end
            SVC_HIGH: if (ret) nxt = SVC_IDLE;
            SVC_NEST: if (ret) nxt = SVC_LOW;
        endcase
    end

    always_comb begin
        allow_hi = 1'b0;
        allow_lo = 1'b0;
        unique case (state)
            SVC_IDLE: begin allow_hi = 1'b1; allow_lo = 1'b1; end
            SVC_LOW:  allow_hi = 1'b1;
            SVC_HIGH: ;
            SVC_NEST: ;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     VEC_BASE  = 16'h0003,
    parameter int              VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gie,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_prio,
    input  logic [NUM_PINS-1:0] ext_type,
    input  logic [NUM_PINS-1:0] ext_n,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              ser_req,
    input  logic              tmr2_req,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec
);
    logic [NUM_SRC-1:0]  pend;
    logic [NUM_PINS-1:0] pin_pend;
    logic [1:0]          tmr_q;
    logic [1:0]          tmr_pulse;
    logic [IDX_W-1:0]    sel_idx;
    logic                sel_hi;
    logic                allow_hi, allow_lo;
    logic                ack_fire;
    svc_state_t          svc_state;

    assign ack_fire  = irq_ack && irq_req && !irq_ret;
    assign tmr_pulse = {tmr1_ovf, tmr0_ovf};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irqc_pin_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[p]),
            .edge_mode (ext_type[p]),
            .clr       (ack_fire && (sel_idx == IDX_W'(2 * p))),
            .pend      (pin_pend[p])
        );
    end

    for (genvar t = 0; t < 2; t++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmr_q[t] <= 1'b0;
            else if (tmr_pulse[t])
                tmr_q[t] <= 1'b1;
            else if (ack_fire && (sel_idx == IDX_W'(2 * t + 1)))
                tmr_q[t] <= 1'b0;
        end
    end

    assign pend = {tmr2_req, ser_req, tmr_q[1], pin_pend[1], tmr_q[0], pin_pend[0]};

    irqc_arbiter #(.NSRC(NUM_SRC), .IW(IDX_W)) u_arb (
        .pend     (pend),
        .en_mask  (src_en),
        .glob     (gie),
        .prio     (src_prio),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo),
        .valid    (irq_req),
        .idx      (sel_idx),
        .is_hi    (sel_hi)
    );

    irqc_svc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (ack_fire),
        .take_hi  (sel_hi),
        .ret      (irq_ret),
        .state    (svc_state),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo)
    );

    assign irq_vec = ADDR_W'(VEC_BASE) + (ADDR_W'(sel_idx) << VEC_SHIFT);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       gie,
    input logic       irq_req,
    input logic [15:0] irq_vec,
    input logic       irq_ack,
    input logic       irq_ret,
    input svc_state_t svc_state
);
    // R1
    gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);

    // R5
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3) && (irq_vec <= 16'h002B));

    // R7
    hi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state == SVC_HIGH || svc_state == SVC_NEST) |-> !irq_req);

    // R8
    nest_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && svc_state == SVC_NEST) |=> (svc_state == SVC_LOW));

    // R13
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_ret) |=> $stable(svc_state));
endmodule

bind irq_vector_ctrl irqc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .svc_state (svc_state)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gie = 1'b0;
    logic [5:0]  src_en = '0, src_prio = '0;
    logic [1:0]  ext_type = '0, ext_n = 2'b11;
    logic        tmr0_ovf = 0, tmr1_ovf = 0, ser_req = 0, tmr2_req = 0;
    logic        irq_ack = 0, irq_ret = 0;
    logic        irq_req;
    logic [15:0] irq_vec;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .gie(gie), .src_en(src_en), .src_prio(src_prio),
        .ext_type(ext_type), .ext_n(ext_n), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ser_req(ser_req), .tmr2_req(tmr2_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {req, vec}: 17'h0 means no request
    task automatic chk_rv(input string tag, input logic [16:0] exp);
        chk(tag, irq_req ? {15'd0, 1'b1, irq_vec} : 32'd0,
            exp[16] ? {15'd0, exp} : 32'd0);
    endtask

    function automatic logic [16:0] vec_of(input int i);
        return {1'b1, 16'(16'h0003 + 8 * i)};
    endfunction

    function automatic logic [16:0] model(input logic g, input logic [5:0] pend,
                                          input logic [5:0] en, input logic [5:0] pr,
                                          input logic ah, input logic al);
        logic [5:0] e;
        e = pend & en & {6{g}};
        for (int i = 0; i < 6; i++)
            if (e[i] && pr[i]) return ah ? vec_of(i) : 17'd0;
        for (int i = 0; i < 6; i++)
            if (e[i]) return al ? vec_of(i) : 17'd0;
        return 17'd0;
    endfunction

    task automatic pulse_ack();
        @(negedge clk) irq_ack = 1;
        @(negedge clk) irq_ack = 0;
        #1;
    endtask

    task automatic pulse_ret();
        @(negedge clk) irq_ret = 1;
        @(negedge clk) irq_ret = 0;
        #1;
    endtask

    task automatic drive_settle();
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 reset no request", irq_req, 0);

        // R1 global enable off masks everything
        src_en = 6'h3F; ser_req = 1; drive_settle();
        chk("R1 gie=0", irq_req, 0);
        gie = 1; drive_settle();
        chk_rv("R5 serial vector", vec_of(4));

        // R2 enable mask
        src_en = 6'h20; tmr2_req = 1; drive_settle();
        chk_rv("R2 only timer2 enabled", vec_of(5));
        src_en = 6'h00; drive_settle();
        chk("R2 all disabled", irq_req, 0);

        // R4 polling order with level pins
        src_en = 6'h3F; ext_n = 2'b00; drive_settle();
        chk_rv("R4 ext0 first", vec_of(0));
        ext_n = 2'b01; drive_settle();
        chk_rv("R4 ext1 over serial", vec_of(2));

        // R3 priority beats order
        ext_n = 2'b10; src_prio = 6'h20; drive_settle();
        chk_rv("R3 high timer2 over low ext0", vec_of(5));
        ext_n = 2'b11; tmr2_req = 0; ser_req = 0; src_prio = 6'h20; drive_settle();

        // R6 R7 R8 R12 nesting
        ser_req = 1; drive_settle();
        chk_rv("R6 low serial presented", vec_of(4));
        pulse_ack();
        chk("R6 low masked in low service", irq_req, 0);
        tmr2_req = 1; drive_settle();
        chk_rv("R6 high preempts low", vec_of(5));
        pulse_ack();
        chk("R7 nothing in nested", irq_req, 0);
        pulse_ret();
        chk_rv("R8 R12 back to low, timer2 again", vec_of(5));
        tmr2_req = 0; drive_settle();
        chk("R8 still low level", irq_req, 0);
        pulse_ret();
        chk_rv("R8 R12 idle, serial again", vec_of(4));
        ser_req = 0; tmr2_req = 1; drive_settle();
        pulse_ack();
        ser_req = 1; drive_settle();
        chk("R7 high-only blocks low", irq_req, 0);
        pulse_ret();
        tmr2_req = 0; ser_req = 0; drive_settle();

        // R13 stray acknowledge
        pulse_ack();
        ser_req = 1; drive_settle();
        chk_rv("R13 stray ack ignored", vec_of(4));
        ser_req = 0; src_prio = 6'h00; drive_settle();

        // R9 edge mode
        ext_type = 2'b01; src_en = 6'h01;
        @(negedge clk) ext_n[0] = 0;
        @(negedge clk); #1;
        chk_rv("R9 edge latched", vec_of(0));
        ext_n[0] = 1;
        @(negedge clk); #1;
        chk_rv("R9 held after pin rises", vec_of(0));
        ext_n[0] = 0;
        @(negedge clk); #1;
        pulse_ack();
        chk("R9 cleared by ack, pin low", irq_req, 0);
        pulse_ret();
        chk("R9 no re-request while low", irq_req, 0);
        ext_n[0] = 1; ext_type = 2'b00;

        // R10 level mode
        src_en = 6'h04;
        ext_n[1] = 0; drive_settle();
        chk_rv("R10 level low requests", vec_of(2));
        ext_n[1] = 1; drive_settle();
        chk("R10 level high no request", irq_req, 0);

        // R11 timer flags
        src_en = 6'h0A;
        @(negedge clk) tmr1_ovf = 1;
        @(negedge clk) tmr1_ovf = 0; #1;
        chk_rv("R11 timer1 latched", vec_of(3));
        @(negedge clk) tmr0_ovf = 1;
        @(negedge clk) tmr0_ovf = 0; #1;
        chk_rv("R11 timer0 over timer1", vec_of(1));
        pulse_ack();
        pulse_ret();
        chk_rv("R11 timer0 cleared, timer1 remains", vec_of(3));
        pulse_ack();
        pulse_ret();
        chk("R11 both cleared", irq_req, 0);

        // random arbitration in idle (R2 R3 R4 R5)
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            gie      = ($urandom % 8) != 0;
            src_en   = 6'($urandom);
            src_prio = 6'($urandom);
            ext_n    = 2'($urandom);
            ser_req  = 1'($urandom);
            tmr2_req = 1'($urandom);
            #1;
            chk_rv("R4 random arbitration",
                   model(gie, {tmr2_req, ser_req, 1'b0, ~ext_n[1], 1'b0, ~ext_n[0]},
                         src_en, src_prio, 1'b1, 1'b1));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule